// File: doc/BRIEF.md
# DRAM Open-Row Read Command Sequencer

This block turns read requests into a stream of DRAM commands. A request carries a bank, a row and a column and arrives on a valid/ready port. The block keeps a table of which row, if any, sits in each bank's row buffer, and it uses that table to pick a command sequence.

- **Row hit:** a column read is issued on its own.
- **Bank closed:** an activate is issued, then the read.
- **Different row open:** a precharge, then an activate, then the read.

Every gap between commands is counted in bus clock cycles, where the bus clock runs at half the transfer rate. The minimum gaps come from module parameters and are enforced with down-counters.

A free-running refresh timer spreads refreshes over the retention time. Its interval is `RETENTION_CYC / (ROWS / ROWS_PER_REF)` cycles. When the timer expires, the block:

1. stops taking requests;
2. precharges every open bank, one per cycle;
3. issues one all-bank refresh for the next group of `ROWS_PER_REF` rows;
4. waits the refresh recovery time.

Back-pressure rules on the request port:

- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- The requester must hold the request and its fields stable until that edge.
- `req_ready` is low while a sequence is in progress, during a command gap, and whenever a refresh is due.
- `req_ready` never depends on `req_valid`.

Top module: `dram_row_seq`

## Requirements
- R1: After reset, all banks are closed, `cmd_type` is 0 (no command), `rd_done` is 0 and `req_ready` is 1.
- R2: A request whose bank holds the same row produces exactly one read (`cmd_type` 4'b0100), issued on the handshake edge, with no precharge or activate.
- R3: A request whose bank holds another row produces a precharge (4'b0001) on the handshake edge, then an activate (4'b0010) exactly `T_RP` cycles later, then a read exactly `T_RCD` cycles after the activate.
- R4: A request to a closed bank produces an activate on the handshake edge and a read exactly `T_RCD` cycles later.
- R5: Activate and read commands carry the request's bank and row, and the read also carries its column. A read is only ever sent to the row that is open in that bank.
- R6: After a read, no command is issued for `BURST` cycles, and `req_ready` stays low for that time.
- R7: `rd_done` pulses for one cycle exactly `T_CL + BURST` cycles after each read command.
- R8: A refresh becomes due every `REF_INTERVAL = RETENTION_CYC / (ROWS / ROWS_PER_REF)` cycles, counted from reset release. From the moment it is due until the refresh command is issued, `req_ready` is low. The refresh follows within a few tens of cycles.
- R9: Before a refresh, each open bank receives a precharge, one per cycle. The refresh (4'b1000) is issued only when all banks are closed and at least `T_RP` cycles after the last precharge. No command follows it for `T_RFC` cycles.
- R10: The refresh carries in `cmd_row` the first row of its group (group index × `ROWS_PER_REF`). The group index starts at 0, rises by one per refresh, and wraps to 0 after group `ROWS/ROWS_PER_REF - 1`.
- R11: At most one command is issued per cycle. `cmd_type` is one-hot (bit 0 precharge, bit 1 activate, bit 2 read, bit 3 refresh) or all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block accepts a request on this edge |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_type | output | 4 | One-hot command, 0 = none |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row (group start row for refresh) |
| cmd_col | output | COL_W | Command column |
| rd_done | output | 1 | Read data burst complete |

## Verification
A stale or wrong entry in the open-row table shows up at the ports on the very next request to that bank. The command sequence seen at the ports would be the wrong kind: a read without an activate, or a needless precharge.

A gap counter that is loaded or decremented wrongly moves the next command off its exact expected cycle. That shows up within a few cycles.

A fault in the refresh timer or in the group counter is seen only at the next refresh. The refresh command would come in the wrong cycle window or carry the wrong group start row. A fault on the wrap is seen once per full pass over all groups.

// File: rtl/drseq_pkg.sv
package drseq_pkg;
  typedef enum logic [3:0] {
    CMD_NONE = 4'b0000,
    CMD_PRE  = 4'b0001,
    CMD_ACT  = 4'b0010,
    CMD_RD   = 4'b0100,
    CMD_REF  = 4'b1000
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_RD,
    ST_REFPRE
  } st_e;
endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int BANKS = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic [BANK_W-1:0] lk_bank,
  output logic              lk_open,
  output logic [ROW_W-1:0]  lk_row,
  output logic [BANKS-1:0]  open_vec
);
  logic [ROW_W-1:0] row_arr [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic             v_q;
    logic [ROW_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (open_en && open_bank == BANK_W'(g)) begin
        v_q <= 1'b1;
        r_q <= open_row;
      end else if (close_en && close_bank == BANK_W'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign open_vec[g] = v_q;
    assign row_arr[g]  = r_q;
  end

  assign lk_open = open_vec[lk_bank];
  assign lk_row  = row_arr[lk_bank];

  // an activate only ever targets a closed bank (R3, R4)
  assert_act_on_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !open_vec[open_bank]);
  // a precharge only ever targets an open bank (R9)
  assert_pre_on_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |-> open_vec[close_bank]);
endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int INTERVAL = 1000,
  parameter int GROUPS = 8,
  parameter int GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [GRP_W-1:0] grp
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [GRP_W-1:0] LAST = GRP_W'(GROUPS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CNT_W'(INTERVAL - 1);
      ref_pend <= 1'b0;
      grp      <= '0;
    end else begin
      cnt_q    <= expire ? CNT_W'(INTERVAL - 1) : cnt_q - 1'b1;
      ref_pend <= (ref_pend && !ref_done) || expire;
      if (ref_done) grp <= (grp == LAST) ? '0 : grp + 1'b1;
    end
  end

  // group counter returns to zero after the last group (R10)
  assert_grp_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && grp == LAST) |=> grp == '0);
  // an expiry never lands on a refresh that is still owed (R8)
  assert_no_lost_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (!ref_pend || ref_done));
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int LAT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_in,
  output logic done_out
);
  logic [LAT-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAT-2:0], rd_in};
  end

  assign done_out = sh_q[LAT-1];
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import drseq_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W = 10,
  parameter int COL_W = 8,
  parameter int T_RP = 3,
  parameter int T_RCD = 4,
  parameter int T_RFC = 20,
  parameter int BURST = 4,
  parameter int ROWS_PER_REF = 128,
  parameter int GRP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              ref_pend,
  input  logic [GRP_W-1:0]  grp,
  input  logic [BANKS-1:0]  open_vec,
  input  logic              lk_open,
  input  logic [ROW_W-1:0]  lk_row,
  output logic [BANK_W-1:0] lk_bank,
  output logic              open_en,
  output logic [ROW_W-1:0]  open_row,
  output logic              close_en,
  output logic [BANK_W-1:0] close_bank,
  output logic              ref_done,
  output cmd_e              cmd_q,
  output logic [BANK_W-1:0] cmd_bank_q,
  output logic [ROW_W-1:0]  cmd_row_q,
  output logic [COL_W-1:0]  cmd_col_q
);
  localparam int M1 = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int M2 = (T_RFC > BURST) ? T_RFC : BURST;
  localparam int GAP_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(GAP_MAX + 1);

  st_e st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_val;
  logic cnt_load;
  logic [BANK_W-1:0] hold_bank;
  logic [ROW_W-1:0]  hold_row;
  logic [COL_W-1:0]  hold_col;
  logic [BANK_W-1:0] cur_bank, pick;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic accept, gap_done;
  cmd_e c_n;
  logic [BANK_W-1:0] b_n;
  logic [ROW_W-1:0]  r_n;
  logic [COL_W-1:0]  col_n;

  assign gap_done  = (cnt_q == '0);
  assign req_ready = (st_q == ST_IDLE) && gap_done && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign cur_bank  = (st_q == ST_IDLE) ? req_bank : hold_bank;
  assign cur_row   = (st_q == ST_IDLE) ? req_row  : hold_row;
  assign cur_col   = (st_q == ST_IDLE) ? req_col  : hold_col;
  assign lk_bank   = cur_bank;
  assign open_row  = cur_row;

  always_comb begin
    pick = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (open_vec[i]) pick = BANK_W'(i);
    end
  end

  always_comb begin
    st_n       = st_q;
    c_n        = CMD_NONE;
    b_n        = cur_bank;
    r_n        = cur_row;
    col_n      = '0;
    cnt_load   = 1'b0;
    cnt_val    = '0;
    open_en    = 1'b0;
    close_en   = 1'b0;
    close_bank = cur_bank;
    ref_done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_load = 1'b1;
          if (lk_open && lk_row == req_row) begin
            c_n     = CMD_RD;
            col_n   = req_col;
            cnt_val = CNT_W'(BURST - 1);
          end else if (lk_open) begin
            c_n      = CMD_PRE;
            r_n      = '0;
            close_en = 1'b1;
            cnt_val  = CNT_W'(T_RP - 1);
            st_n     = ST_ACT;
          end else begin
            c_n     = CMD_ACT;
            open_en = 1'b1;
            cnt_val = CNT_W'(T_RCD - 1);
            st_n    = ST_RD;
          end
        end else if (ref_pend && gap_done) begin
          st_n = ST_REFPRE;
        end
      end
      ST_ACT: begin
        if (gap_done) begin
          c_n      = CMD_ACT;
          open_en  = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_RCD - 1);
          st_n     = ST_RD;
        end
      end
      ST_RD: begin
        if (gap_done) begin
          c_n      = CMD_RD;
          col_n    = cur_col;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(BURST - 1);
          st_n     = ST_IDLE;
        end
      end
      ST_REFPRE: begin
        if (|open_vec) begin
          c_n        = CMD_PRE;
          b_n        = pick;
          r_n        = '0;
          close_en   = 1'b1;
          close_bank = pick;
          cnt_load   = 1'b1;
          cnt_val    = CNT_W'(T_RP - 1);
        end else if (gap_done) begin
          c_n      = CMD_REF;
          b_n      = '0;
          r_n      = ROW_W'(32'(grp) * ROWS_PER_REF);
          ref_done = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_RFC - 1);
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      hold_bank  <= '0;
      hold_row   <= '0;
      hold_col   <= '0;
      cmd_q      <= CMD_NONE;
      cmd_bank_q <= '0;
      cmd_row_q  <= '0;
      cmd_col_q  <= '0;
    end else begin
      st_q <= st_n;
      if (cnt_load)       cnt_q <= cnt_val;
      else if (!gap_done) cnt_q <= cnt_q - 1'b1;
      if (accept) begin
        hold_bank <= req_bank;
        hold_row  <= req_row;
        hold_col  <= req_col;
      end
      cmd_q      <= c_n;
      cmd_bank_q <= b_n;
      cmd_row_q  <= r_n;
      cmd_col_q  <= col_n;
    end
  end

  // one command per cycle, one-hot or none (R11)
  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NONE) |-> $onehot(cmd_q));
  // a delayed read finds its row open in the table (R5)
  assert_rd_open_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD && gap_done) |-> (lk_open && lk_row == hold_row));
  // a refresh command sees every bank closed (R9)
  assert_ref_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_vec == '0));
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq #(
  parameter int BANKS = 4,
  parameter int ROWS = 1024,
  parameter int COLS = 256,
  parameter int ROWS_PER_REF = 128,
  parameter int RETENTION_CYC = 8000,
  parameter int T_RP = 3,
  parameter int T_RCD = 4,
  parameter int T_CL = 5,
  parameter int BURST = 4,
  parameter int T_RFC = 20,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [3:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              rd_done
);
  import drseq_pkg::*;

  localparam int GROUPS = ROWS / ROWS_PER_REF;
  localparam int REF_INTERVAL = RETENTION_CYC / GROUPS;
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int LAT = T_CL + BURST;

  logic              ref_pend, ref_done;
  logic [GRP_W-1:0]  grp;
  logic [BANKS-1:0]  open_vec;
  logic              lk_open, open_en, close_en;
  logic [ROW_W-1:0]  lk_row, open_row;
  logic [BANK_W-1:0] lk_bank, close_bank;
  cmd_e              cmd_q;

  open_row_table #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .open_en(open_en), .open_bank(lk_bank), .open_row(open_row),
    .close_en(close_en), .close_bank(close_bank),
    .lk_bank(lk_bank), .lk_open(lk_open), .lk_row(lk_row),
    .open_vec(open_vec)
  );

  ref_timer #(.INTERVAL(REF_INTERVAL), .GROUPS(GROUPS), .GRP_W(GRP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
    .ref_pend(ref_pend), .grp(grp)
  );

  cmd_fsm #(
    .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .BURST(BURST),
    .ROWS_PER_REF(ROWS_PER_REF), .GRP_W(GRP_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .ref_pend(ref_pend), .grp(grp),
    .open_vec(open_vec), .lk_open(lk_open), .lk_row(lk_row),
    .lk_bank(lk_bank), .open_en(open_en), .open_row(open_row),
    .close_en(close_en), .close_bank(close_bank), .ref_done(ref_done),
    .cmd_q(cmd_q), .cmd_bank_q(cmd_bank), .cmd_row_q(cmd_row),
    .cmd_col_q(cmd_col)
  );

  rd_lat_pipe #(.LAT(LAT)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .rd_in(cmd_q == CMD_RD), .done_out(rd_done)
  );

  assign cmd_type = cmd_q;
endmodule

// File: tb/dram_row_seq_tb.sv
module dram_row_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 4, ROWS = 1024, COLS = 256, ROWS_PER_REF = 128;
  localparam int RETENTION_CYC = 8000;
  localparam int T_RP = 3, T_RCD = 4, T_CL = 5, BURST = 4, T_RFC = 20;
  localparam int BANK_W = 2, ROW_W = 10, COL_W = 8;
  localparam int GROUPS = ROWS / ROWS_PER_REF;
  localparam int REF_INTERVAL = RETENTION_CYC / GROUPS;
  localparam int RST_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rd_done;
  logic [BANK_W-1:0] req_bank = '0, cmd_bank;
  logic [ROW_W-1:0]  req_row = '0, cmd_row;
  logic [COL_W-1:0]  req_col = '0, cmd_col;
  logic [3:0] cmd_type;

  dram_row_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .rd_done(rd_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench-side functions giving expected values
  function automatic int grp_row(input int g);
    return (g % GROUPS) * ROWS_PER_REF;
  endfunction
  function automatic int ref_due(input int k);
    return k * REF_INTERVAL + RST_CYC;
  endfunction

  // bench model of the bank state
  bit mopen [BANKS];
  int mrow  [BANKS];
  bit busy = 0;
  int e_n, e_idx, e_bank, e_row, e_col;
  int e_type [3];
  int e_cyc  [3];
  string e_tag;
  int dq [$];
  int last_ref = -1, last_pre = -1, last_rd = -1000, nref = 0;

  task automatic send(input int b, input int r, input int c);
    int acc;
    @(negedge clk);
    req_valid = 1'b1;
    req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc = cyc;
    req_valid = 1'b0;
    e_bank = b; e_row = r; e_col = c; e_idx = 0;
    if (mopen[b] && mrow[b] == r) begin
      e_tag = "R2"; e_n = 1;
      e_type[0] = 4; e_cyc[0] = acc;
    end else if (mopen[b]) begin
      e_tag = "R3"; e_n = 3;
      e_type[0] = 1; e_cyc[0] = acc;
      e_type[1] = 2; e_cyc[1] = acc + T_RP;
      e_type[2] = 4; e_cyc[2] = acc + T_RP + T_RCD;
    end else begin
      e_tag = "R4"; e_n = 2;
      e_type[0] = 2; e_cyc[0] = acc;
      e_type[1] = 4; e_cyc[1] = acc + T_RCD;
    end
    busy = 1;
    while (busy) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      // R7 read completion timing
      if (dq.size() > 0 && dq[0] < cyc) begin
        check(0, "R7", "rd_done missing at cycle", cyc, dq[0]);
        void'(dq.pop_front());
      end
      if (rd_done) begin
        if (dq.size() > 0 && dq[0] == cyc) begin
          check(1, "R7", "rd_done", cyc, cyc);
          void'(dq.pop_front());
        end else begin
          check(0, "R7", "unexpected rd_done at cycle", cyc, -1);
        end
      end
      // R8 requests held off while a refresh is due
      if (cyc >= ref_due(nref + 1) + 1)
        check(!req_ready, "R8", "req_ready while refresh due", int'(req_ready), 0);
      if (cmd_type != 4'b0000) begin
        check($onehot(cmd_type), "R11", "cmd_type one-hot", int'(cmd_type), 1);
        check(cyc - last_rd >= BURST, "R6", "gap after read", cyc - last_rd, BURST);
        if (last_ref >= 0 && cyc - last_ref < T_RFC)
          check(0, "R9", "command inside refresh recovery", cyc - last_ref, T_RFC);
        if (busy) begin
          check(int'(cmd_type) == e_type[e_idx], e_tag, "command type",
                int'(cmd_type), e_type[e_idx]);
          check(cyc == e_cyc[e_idx], e_tag, "command cycle", cyc, e_cyc[e_idx]);
          check(int'(cmd_bank) == e_bank, "R5", "command bank", int'(cmd_bank), e_bank);
          if (cmd_type == 4'b0010 || cmd_type == 4'b0100)
            check(int'(cmd_row) == e_row, "R5", "command row", int'(cmd_row), e_row);
          if (cmd_type == 4'b0001) mopen[e_bank] = 0;
          if (cmd_type == 4'b0010) begin
            mopen[e_bank] = 1; mrow[e_bank] = e_row;
          end
          if (cmd_type == 4'b0100) begin
            check(int'(cmd_col) == e_col, "R5", "read column", int'(cmd_col), e_col);
            check(mopen[e_bank] && mrow[e_bank] == e_row, "R5", "read to open row",
                  int'(mopen[e_bank]), 1);
            dq.push_back(cyc + T_CL + BURST);
            last_rd = cyc;
            busy = 0;
          end
          e_idx++;
        end else if (cmd_type == 4'b0001) begin
          check(mopen[int'(cmd_bank)], "R9", "refresh precharge of open bank",
                int'(mopen[int'(cmd_bank)]), 1);
          mopen[int'(cmd_bank)] = 0;
          last_pre = cyc;
        end else if (cmd_type == 4'b1000) begin
          automatic int nopen = 0;
          foreach (mopen[i]) nopen += int'(mopen[i]);
          check(nopen == 0, "R9", "open banks at refresh", nopen, 0);
          if (last_pre >= 0)
            check(cyc - last_pre >= T_RP, "R9", "precharge to refresh gap",
                  cyc - last_pre, T_RP);
          check(int'(cmd_row) == grp_row(nref), "R10", "refresh group row",
                int'(cmd_row), grp_row(nref));
          check(cyc > ref_due(nref + 1) && cyc <= ref_due(nref + 1) + 60, "R8",
                "refresh cycle", cyc, ref_due(nref + 1) + 1);
          nref++;
          last_ref = cyc;
        end else begin
          check(0, "R5", "request command with no request", int'(cmd_type), 0);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (mopen[i]) begin mopen[i] = 0; mrow[i] = 0; end
    void'($urandom(32'd715));
    repeat (RST_CYC) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(cmd_type == 4'b0000, "R1", "cmd_type after reset", int'(cmd_type), 0);
    check(rd_done == 1'b0, "R1", "rd_done after reset", int'(rd_done), 0);
    // directed: closed bank (R4), hit (R2), conflict (R3), back-to-back hits (R6)
    send(0, 5, 1);
    send(0, 5, 2);
    send(0, 6, 3);
    send(1, 7, 0);
    send(1, 7, 9);
    send(1, 7, 10);
    send(3, ROWS - 1, COLS - 1);
    // random traffic across enough refreshes to wrap the group counter (R10)
    while (cyc < ref_due(GROUPS + 1) + 200) begin
      automatic int gap = $urandom_range(0, 12);
      automatic int rsel = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      send($urandom_range(0, BANKS - 1), (rsel == 0) ? 3 : (rsel == 1) ? 40 : 777,
           $urandom_range(0, COLS - 1));
    end
    repeat (40) @(negedge clk);
    check(nref >= GROUPS + 1, "R10", "refreshes seen past wrap", nref, GROUPS + 1);
    check(dq.size() == 0, "R7", "outstanding rd_done", dq.size(), 0);
    finish_run();
  end
endmodule